// File: doc/BRIEF.md
# DDR2 Refresh Scheduler

This block keeps a DDR2 memory refreshed on behalf of a controller's command sequencer. A down-counter, reloaded from a programmable refresh-rate value counted in controller clocks, marks the end of each refresh interval. Each expiry adds one refresh to a small debt counter. The counter reloads at once on expiry, so the interval does not stretch while the block waits for the bus.

While refreshes are owed and the scheduler is idle, it raises a bus request. When the sequencer grants the bus and reports no burst in progress, the scheduler takes over the command outputs. It issues a precharge-all with address bit 10 high, waits a programmable row-precharge time, then issues an auto-refresh. After a programmable refresh-cycle time it pulses an invalidate signal, so the sequencer discards every open-row record. It then releases the bus and pays off one owed refresh. When the debt reaches eight, an urgent flag tells the sequencer to let refresh go ahead of pending data requests.

States of the sequencing machine are IDLE, PALL, WAIT_RP, REF, WAIT_RFC and DONE. The transitions are:

- IDLE to PALL when a refresh is owed, the grant is high and busy is low.
- PALL to WAIT_RP, or straight to REF when the precharge wait is 1 or less.
- WAIT_RP to REF when its wait ends.
- REF to WAIT_RFC, or straight to DONE when the refresh wait is 1 or less.
- WAIT_RFC to DONE when its wait ends.
- DONE to IDLE, always.

Top module: `ddr2_refresh_sched`

## Requirements
- R1: After reset, `bus_req`, `bus_own`, `urgent` and `rows_inval` are low, and the command outputs show deselect (`cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` all 1, `cmd_a10` 0).
- R2: A pulse on `rate_wr` that carries N ≥ 1 on `rate_val` makes the first refresh owed on the Nth clock edge after the edge that samples the write, and one more every N edges after that. Writing 0 acts as writing 1.
- R3: A write of the rate restarts the interval from the new value and discards the partly elapsed count. An expiry that coincides with a write is dropped.
- R4: The machine leaves IDLE only on an edge where a refresh is owed, `bus_grant` is 1 and `seq_busy` is 0.
- R5: The first command of every refresh is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. It lasts one cycle and appears in the cycle after the granting edge.
- R6: The refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1) follows the precharge-all by exactly `trp_cyc` cycles (a value of 0 acts as 1). No other command lies between them.
- R7: `rows_inval` pulses for one cycle exactly `trfc_cyc` cycles after the refresh command (0 acts as 1). In the next cycle `bus_own` is low.
- R8: The interval counter keeps running while a refresh waits for the bus or is in progress, so refreshes start one interval apart whenever the bus is available.
- R9: At most 8 refreshes are owed. Expiries beyond that are lost. `urgent` is 1 exactly while 8 are owed.
- R10: `bus_own` is high from the precharge-all cycle through the invalidate cycle, without a gap. It rises only together with a precharge-all.
- R11: While `bus_own` is low the command outputs show deselect. In the wait cycles inside a refresh they show a no-operation (cs_n=0, others 1, a10=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_val | input | RATE_W | Refresh interval in clocks |
| rate_wr | input | 1 | Write strobe for the interval; restarts the counter |
| trp_cyc | input | T_W | Cycles from precharge-all to refresh |
| trfc_cyc | input | T_W | Cycles from refresh to the release of the bus |
| seq_busy | input | 1 | Sequencer has a burst in progress |
| bus_grant | input | 1 | Sequencer lets refresh take the command bus |
| bus_req | output | 1 | A refresh is owed and the scheduler is idle |
| bus_own | output | 1 | Scheduler drives the command bus |
| urgent | output | 1 | Refresh debt is full; refresh must win over data |
| rows_inval | output | 1 | One-cycle pulse: clear all open-row records |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10; high selects all banks on precharge |

## Verification
A rate written on edge w makes `bus_req` visible after edge w+N, and `urgent` after edge w+8N. A grant sampled on edge g puts the precharge-all in the cycle that follows g. The refresh command comes `trp_cyc` cycles after that, and the invalidate pulse `trfc_cyc` cycles after the refresh. The bench counts rising edges and reads every output half a period after an edge, so each event carries the number of the edge that produced it. It compares that number with the expected edge, computed from the written rate and wait values across sweeps of rates and of both waits. Debt saturation is checked by counting the invalidate pulses needed to drain the block after a long run of expiries.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC,
        ST_DONE
    } rs_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam ddr_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam ddr_cmd_t CMD_PREA  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam ddr_cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
endpackage

// File: rtl/refsch_timer.sv
module refsch_timer #(
    parameter int RATE_W   = 16,
    parameter int RST_RATE = 1560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              rate_wr,
    output logic              expire
);
    localparam logic [RATE_W-1:0] RST_LOAD = RATE_W'(RST_RATE - 1);

    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] reload;

    // A rate of zero behaves as one clock.
    assign reload = (rate_val == '0) ? '0 : rate_val - RATE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RST_LOAD;
        end else if (rate_wr) begin
            cnt <= reload;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - RATE_W'(1);
        end
    end

    assign expire = (cnt == '0) && !rate_wr;

    // A rate write above one leaves at least one quiet cycle before expiry.
    assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_wr && rate_val > RATE_W'(1)) |=> !expire);
endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic sub,
    output logic pending,
    output logic urgent
);
    localparam int CW = $clog2(MAX_OWED + 1);
    localparam logic [CW-1:0] FULL = CW'(MAX_OWED);

    logic [CW-1:0] owed;
    logic          do_add;
    logic          do_sub;

    assign do_add = add && (owed != FULL);
    assign do_sub = sub && (owed != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({do_add, do_sub})
                2'b10:   owed <= owed + CW'(1);
                2'b01:   owed <= owed - CW'(1);
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);
    assign urgent  = (owed == FULL);

    assert_debt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= FULL);
    assert_debt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && !sub) |=> urgent);
endmodule

// File: rtl/refsch_fsm.sv
module refsch_fsm
    import refsch_pkg::*;
#(
    parameter int T_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pending,
    input  logic           bus_grant,
    input  logic           seq_busy,
    input  logic [T_W-1:0] trp_cyc,
    input  logic [T_W-1:0] trfc_cyc,
    output logic           bus_req,
    output logic           bus_own,
    output logic           rows_inval,
    output ddr_cmd_t       cmd
);
    localparam logic [T_W-1:0] ONE = T_W'(1);

    rs_state_t      state;
    rs_state_t      nxt;
    logic [T_W-1:0] wcnt;
    logic           start;

    assign start = pending && bus_grant && !seq_busy;

    // State register and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PALL) begin
                wcnt <= trp_cyc - ONE;
            end else if (state == ST_REF) begin
                wcnt <= trfc_cyc - ONE;
            end else if (wcnt != '0) begin
                wcnt <= wcnt - ONE;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_PALL;
            ST_PALL:     nxt = (trp_cyc <= ONE) ? ST_REF : ST_WAIT_RP;
            ST_WAIT_RP:  if (wcnt <= ONE) nxt = ST_REF;
            ST_REF:      nxt = (trfc_cyc <= ONE) ? ST_DONE : ST_WAIT_RFC;
            ST_WAIT_RFC: if (wcnt <= ONE) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        bus_req    = 1'b0;
        bus_own    = 1'b1;
        rows_inval = 1'b0;
        cmd        = CMD_NOP;
        unique case (state)
            ST_IDLE: begin
                bus_own = 1'b0;
                bus_req = pending;
                cmd     = CMD_DESEL;
            end
            ST_PALL:     cmd = CMD_PREA;
            ST_WAIT_RP:  cmd = CMD_NOP;
            ST_REF:      cmd = CMD_REF;
            ST_WAIT_RFC: cmd = CMD_NOP;
            ST_DONE: begin
                cmd        = CMD_NOP;
                rows_inval = 1'b1;
            end
            default: begin
                bus_own = 1'b0;
                cmd     = CMD_DESEL;
            end
        endcase
    end

    assert_grant_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(pending && bus_grant && !seq_busy)) |=> !bus_own);
    assert_prea_before_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF) |-> ($past(state) == ST_PALL || $past(state) == ST_WAIT_RP));
    assert_inval_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rows_inval |=> (!rows_inval && !bus_own));
    assert_own_starts_prea_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> (cmd == CMD_PREA));
    assert_desel_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (cmd == CMD_DESEL));
endmodule

// File: rtl/ddr2_refresh_sched.sv
module ddr2_refresh_sched
    import refsch_pkg::*;
#(
    parameter int RATE_W   = 16,
    parameter int T_W      = 8,
    parameter int MAX_OWED = 8,
    parameter int RST_RATE = 1560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              rate_wr,
    input  logic [T_W-1:0]    trp_cyc,
    input  logic [T_W-1:0]    trfc_cyc,
    input  logic              seq_busy,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              bus_own,
    output logic              urgent,
    output logic              rows_inval,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic              cmd_a10
);
    logic     expire;
    logic     pending;
    ddr_cmd_t cmd;

    refsch_timer #(.RATE_W(RATE_W), .RST_RATE(RST_RATE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_val (rate_val),
        .rate_wr  (rate_wr),
        .expire   (expire)
    );

    refsch_debt #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (expire),
        .sub     (rows_inval),
        .pending (pending),
        .urgent  (urgent)
    );

    refsch_fsm #(.T_W(T_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .bus_grant  (bus_grant),
        .seq_busy   (seq_busy),
        .trp_cyc    (trp_cyc),
        .trfc_cyc   (trfc_cyc),
        .bus_req    (bus_req),
        .bus_own    (bus_own),
        .rows_inval (rows_inval),
        .cmd        (cmd)
    );

    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign cmd_a10   = cmd.a10;

    assert_no_req_while_own_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> !bus_req);
endmodule

// File: tb/ddr2_refresh_sched_test.sv
module ddr2_refresh_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rate_val = '0;
    logic        rate_wr = 1'b0;
    logic [7:0]  trp_cyc = 8'd1;
    logic [7:0]  trfc_cyc = 8'd1;
    logic        seq_busy = 1'b0;
    logic        bus_grant = 1'b0;
    logic        bus_req, bus_own, urgent, rows_inval;
    logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int idle_bad = 0;
    int w = 0;

    ddr2_refresh_sched uut (
        .clk(clk), .rst_n(rst_n), .rate_val(rate_val), .rate_wr(rate_wr),
        .trp_cyc(trp_cyc), .trfc_cyc(trfc_cyc), .seq_busy(seq_busy),
        .bus_grant(bus_grant), .bus_req(bus_req), .bus_own(bus_own),
        .urgent(urgent), .rows_inval(rows_inval), .cmd_cs_n(cmd_cs_n),
        .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
        .cmd_a10(cmd_a10)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] cmdv();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10};
    endfunction

    localparam logic [4:0] V_DESEL = 5'b11110;
    localparam logic [4:0] V_NOP   = 5'b01110;
    localparam logic [4:0] V_PREA  = 5'b00101;
    localparam logic [4:0] V_REF   = 5'b00010;

    always @(negedge clk) if (rst_n && !bus_own && cmdv() != V_DESEL) idle_bad++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_rate(input int n);
        @(negedge clk);
        rate_val = 16'(n);
        rate_wr = 1'b1;
        @(negedge clk);
        rate_wr = 1'b0;
        w = cyc;
    endtask

    task automatic wait_req(output int c);
        c = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (bus_req) begin
                c = cyc;
                break;
            end
        end
    endtask

    task automatic drain(output int n);
        set_rate(60000);
        trp_cyc = 8'd1;
        trfc_cyc = 8'd1;
        seq_busy = 1'b0;
        bus_grant = 1'b1;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rows_inval) n++;
            if (!bus_req && !bus_own) break;
        end
        bus_grant = 1'b0;
    endtask

    task automatic run_refresh(input int trp, input int trfc);
        int c, g, prea, refc, inv, nop_bad, gap, own_early, a10ok, ok_after;
        int junk;
        drain(junk);
        set_rate(3);
        wait_req(c);
        set_rate(60000);
        trp_cyc = 8'(trp);
        trfc_cyc = 8'(trfc);
        own_early = 0;
        seq_busy = 1'b1;
        bus_grant = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (bus_own) own_early++;
        end
        seq_busy = 1'b0;
        bus_grant = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (bus_own) own_early++;
        end
        chk(own_early == 0, "R4 no start without grant or while busy", own_early, 0);
        bus_grant = 1'b1;
        g = cyc + 1;
        prea = -1; refc = -1; inv = -1; nop_bad = 0; gap = 0; a10ok = 0; ok_after = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (prea < 0 && cmdv() == V_PREA) begin
                prea = cyc;
                a10ok = 1;
            end else if (refc < 0 && cmdv() == V_REF) begin
                refc = cyc;
            end else if (bus_own && cmdv() != V_NOP) begin
                nop_bad++;
            end
            if (rows_inval && inv < 0) inv = cyc;
            if (prea >= 0 && inv < 0 && !bus_own) gap++;
            if (inv >= 0 && cyc == inv + 1) begin
                ok_after = (!bus_own && !bus_req) ? 1 : 0;
                break;
            end
        end
        bus_grant = 1'b0;
        chk(prea == g, "R5 precharge-all cycle", prea, g);
        chk(a10ok == 1, "R5 precharge-all encoding with a10", a10ok, 1);
        chk(refc - prea == trp, "R6 refresh after precharge-all", refc - prea, trp);
        chk(inv - refc == trfc, "R7 invalidate after refresh", inv - refc, trfc);
        chk(ok_after == 1, "R7 bus released after invalidate", ok_after, 1);
        chk(gap == 0, "R10 bus owned without gap", gap, 0);
        chk(nop_bad == 0, "R11 no-operation in wait cycles", nop_bad, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c, n;
        int rates[4] = '{2, 3, 5, 9};
        int tps[3] = '{1, 2, 5};
        int tfs[3] = '{1, 4, 7};
        int p1, p2, p3, np;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!bus_req && !bus_own && !urgent && !rows_inval, "R1 outputs idle after reset",
            {bus_req, bus_own, urgent, rows_inval}, 0);
        chk(cmdv() == V_DESEL, "R1 deselect after reset", cmdv(), V_DESEL);

        // R2 and R9: interval sweep, saturation of the debt
        foreach (rates[k]) begin
            drain(n);
            set_rate(rates[k]);
            wait_req(c);
            chk(c == w + rates[k], "R2 first refresh owed", c, w + rates[k]);
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                if (urgent) begin
                    c = cyc;
                    break;
                end
            end
            chk(c == w + 8 * rates[k], "R9 urgent at eight owed", c, w + 8 * rates[k]);
            repeat (3 * rates[k]) @(negedge clk);
            chk(urgent == 1'b1, "R9 urgent held while full", urgent, 1);
            drain(n);
            chk(n == 8, "R9 debt saturates at eight", n, 8);
            chk(!urgent, "R9 urgent clears after drain", urgent, 0);
        end

        // R2: a written rate of zero acts as one
        drain(n);
        set_rate(0);
        wait_req(c);
        chk(c == w + 1, "R2 zero rate acts as one", c, w + 1);

        // R3: a rewrite restarts the interval
        drain(n);
        set_rate(10);
        repeat (6) @(negedge clk);
        set_rate(4);
        wait_req(c);
        chk(c == w + 4, "R3 rewrite restarts interval", c, w + 4);

        // R4..R7, R10, R11: sweep of both waits
        foreach (tps[a]) foreach (tfs[b]) run_refresh(tps[a], tfs[b]);

        // R8: the interval keeps running while the bus is held back
        drain(n);
        trp_cyc = 8'd2;
        trfc_cyc = 8'd3;
        bus_grant = 1'b1;
        set_rate(20);
        p1 = -1; p2 = -1; p3 = -1; np = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (cmdv() == V_PREA) begin
                np++;
                if (np == 1) p1 = cyc;
                else if (np == 2) p2 = cyc;
                else if (np == 3) p3 = cyc;
            end
            seq_busy = (cyc >= w + 19 && cyc < w + 28);
        end
        seq_busy = 1'b0;
        bus_grant = 1'b0;
        chk(p1 == w + 29, "R8 delayed first refresh", p1, w + 29);
        chk(p2 == w + 41, "R8 second refresh on schedule", p2, w + 41);
        chk(p3 == w + 61, "R8 third refresh on schedule", p3, w + 61);

        chk(idle_bad == 0, "R11 deselect while not owning", idle_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule